// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital side of an on-chip 8-bit successive-approximation A/D converter. Software reaches it through two register write ports: a control register holding a start bit, a busy/end-of-conversion flag and a 4-bit analog pin-select field, and a configuration register holding a power-down bit and a 3-bit conversion-clock select. A prescaler divides the system clock into an A/D step tick. On each tick the sequencer samples once and then resolves one result bit per tick, from the most significant bit down. It drives a trial code to an external DAC and reads back an external comparator.

A conversion is launched by a complete pulse on the start bit: a write of 1 followed by a write of 0. While the bit stays at 1 the converter is held in reset and the flag reads 1. When the last bit has been resolved, the flag drops to 0, the result register is loaded in one step and an interrupt request flag is raised. The interrupt output follows that flag, gated by an enable input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `eoc_o` is 0, `result_o` is 0, `irq_flag_o` is 0, the clock select is 000 and the converter is powered down, so `cfg_o` reads 8'h80 and `ctrl_o` reads 8'h00.
- R2: `ctrl_o` reads {start, eoc, 2'b00, pin_sel[3:0]} and `cfg_o` reads {pd, 4'b0000, clk_sel[2:0]}. The unused bits are always 0. `analog_en_o` equals pin_sel, so a pin-select of 0000 leaves all four shared pins digital.
- R3: A control write that takes start from 0 to 1 while powered on sets `eoc_o` to 1 on the next cycle. While start stays 1, no conversion makes progress and `eoc_o` stays 1.
- R4: A control write that takes start from 1 to 0 while the converter is held in reset launches a conversion. The conversion is one sample tick followed by 8 bit ticks. Each bit is kept when `cmp_i` is 1 for the trial code on `dac_code_o`, so the result is the binary search of the comparator.
- R5: The clock select sets the ticks to one per N system clocks: 000→N=2, 001→8, 010→32, 100→1, 101→4, 110→16. Counting from the launch edge, `eoc_o` falls on system clock edge 9·N.
- R6: With select 011 or 111, no ticks occur. A start pulse completed under such a code starts nothing: `eoc_o` stays 1, and `result_o` and `irq_flag_o` are unchanged.
- R7: Power-down 1 turns the converter off. A start pulse while powered down is ignored (`eoc_o` unchanged), and setting power-down abandons any conversion in progress.
- R8: A rising start write during a conversion abandons it and sets `eoc_o` to 1. The next falling write starts a fresh conversion.
- R9: On completion `irq_flag_o` is set. `irq_o` equals `irq_flag_o` AND `int_en_i`. `irq_ack_i` clears the flag.
- R10: `result_o` keeps its previous value for the whole conversion and changes only on the cycle in which `eoc_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| start_i | input | 1 | Start bit write data |
| pin_sel_i | input | 4 | Analog pin-select write data |
| cfg_we | input | 1 | Configuration register write strobe |
| pd_i | input | 1 | Power-down write data (1 = off) |
| clk_sel_i | input | 3 | Conversion clock select write data |
| int_en_i | input | 1 | A/D interrupt enable |
| irq_ack_i | input | 1 | Clears the interrupt request flag |
| cmp_i | input | 1 | Comparator: 1 when analog input ≥ DAC code |
| dac_code_o | output | 8 | Trial code to the DAC |
| sample_o | output | 1 | High during the sample phase |
| result_o | output | 8 | Conversion result |
| eoc_o | output | 1 | End-of-conversion flag (1 = busy/reset) |
| analog_en_o | output | 4 | Per-pin analog enable |
| ctrl_o | output | 8 | Control register readback |
| cfg_o | output | 8 | Configuration register readback |
| irq_flag_o | output | 1 | A/D interrupt request flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench times the end-of-conversion edge for every legal divider. A design that mapped the non-monotonic select codes in order, or counted one tick too few or too many, moves that edge off cycle 9·N. Directed cases hold start high, use an illegal select, start while powered down, and restart mid-conversion. A design that launched on the rising edge, ran with a stopped clock, or finished an abandoned conversion would drop `eoc_o` or load a stale result. Random analog levels checked against the comparator search catch wrong bit order, and mid-conversion sampling of `result_o` catches a result register that updates before the conversion ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned MAX_DIV = 32;
  localparam int unsigned DIV_CW  = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } sar_state_e;

  function automatic logic sel_legal(input logic [2:0] sel);
    return (sel[1:0] != 2'b11);
  endfunction

  // Returns the division ratio minus one for a legal select code.
  function automatic logic [DIV_CW-1:0] sel_div_m1(input logic [2:0] sel);
    logic [DIV_CW:0] d;
    case (sel)
      3'b000:  d = 2;
      3'b001:  d = 8;
      3'b010:  d = 32;
      3'b100:  d = 1;
      3'b101:  d = 4;
      3'b110:  d = 16;
      default: d = 1;
    endcase
    return DIV_CW'(d - 1'b1);
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       restart_i,
  output logic       tick_o
);
  logic [DIV_CW-1:0] cnt_q, cnt_d;
  logic [DIV_CW-1:0] lim;
  logic              legal;

  assign legal  = sel_legal(sel_i);
  assign lim    = sel_div_m1(sel_i);
  assign tick_o = legal && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || !legal) begin
      cnt_d = '0;
    end else if (cnt_q >= lim) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> (cnt_q == '0))
    else $error("stopped_clock_chk");

  // R5
  assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart_i) |-> (cnt_q == '0))
    else $error("prescale_restart_chk");
endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_i,
  input  logic          start_rise_i,
  input  logic          start_fall_i,
  input  logic          sel_ok_i,
  input  logic          tick_i,
  input  logic          cmp_i,
  output logic          launch_o,
  output logic          done_o,
  output logic          eoc_o,
  output logic          sample_o,
  output logic [DW-1:0] dac_code_o,
  output logic [DW-1:0] result_o
);
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

  sar_state_e    st_q, st_d;
  logic [DW-1:0] sar_q, sar_d, mask_q, mask_d, res_q, res_d;
  logic          eoc_q, eoc_d;
  logic [DW-1:0] kept;

  assign kept = cmp_i ? sar_q : (sar_q & ~mask_q);

  always_comb begin
    st_d     = st_q;
    sar_d    = sar_q;
    mask_d   = mask_q;
    res_d    = res_q;
    eoc_d    = eoc_q;
    launch_o = 1'b0;
    done_o   = 1'b0;
    if (pd_i) begin
      st_d = ST_IDLE;
    end else if (start_rise_i) begin
      st_d  = ST_HOLD;
      eoc_d = 1'b1;
    end else begin
      case (st_q)
        ST_HOLD: if (start_fall_i) begin
          if (sel_ok_i) begin
            st_d     = ST_SAMPLE;
            launch_o = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_SAMPLE: if (tick_i) begin
          st_d   = ST_CONV;
          sar_d  = MSB_ONLY;
          mask_d = MSB_ONLY;
        end
        ST_CONV: if (tick_i) begin
          if (mask_q[0]) begin
            res_d  = kept;
            eoc_d  = 1'b0;
            st_d   = ST_IDLE;
            sar_d  = kept;
            done_o = 1'b1;
          end else begin
            sar_d  = kept | (mask_q >> 1);
            mask_d = mask_q >> 1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sar_q  <= '0;
      mask_q <= '0;
      res_q  <= '0;
      eoc_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sar_q  <= sar_d;
      mask_q <= mask_d;
      res_q  <= res_d;
      eoc_q  <= eoc_d;
    end
  end

  assign eoc_o      = eoc_q;
  assign sample_o   = (st_q == ST_SAMPLE);
  assign dac_code_o = sar_q;
  assign result_o   = res_q;

  // R3
  assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise_i && !pd_i) |=> eoc_q)
    else $error("hold_sets_eoc_chk");

  // R7
  assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (st_q == ST_IDLE))
    else $error("powerdown_idle_chk");

  // R10
  assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> !eoc_q)
    else $error("atomic_result_chk");

  // R4
  assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV) |-> $onehot0(mask_q))
    else $error("one_bit_step_chk");
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            start_i,
  input  logic [NPIN-1:0] pin_sel_i,
  input  logic            cfg_we,
  input  logic            pd_i,
  input  logic [2:0]      clk_sel_i,
  input  logic            int_en_i,
  input  logic            irq_ack_i,
  input  logic            cmp_i,
  output logic [DW-1:0]   dac_code_o,
  output logic            sample_o,
  output logic [DW-1:0]   result_o,
  output logic            eoc_o,
  output logic [NPIN-1:0] analog_en_o,
  output logic [7:0]      ctrl_o,
  output logic [7:0]      cfg_o,
  output logic            irq_flag_o,
  output logic            irq_o
);
  logic            start_q, start_d;
  logic [NPIN-1:0] pin_q, pin_d;
  logic            pd_q, pd_d;
  logic [2:0]      sel_q, sel_d;
  logic            irqf_q, irqf_d;
  logic            rise, fall, tick, launch, done;

  assign rise = ctrl_we && !start_q && start_i;
  assign fall = ctrl_we && start_q && !start_i;

  always_comb begin
    start_d = start_q;
    pin_d   = pin_q;
    pd_d    = pd_q;
    sel_d   = sel_q;
    irqf_d  = irqf_q;
    if (ctrl_we) begin
      start_d = start_i;
      pin_d   = pin_sel_i;
    end
    if (cfg_we) begin
      pd_d  = pd_i;
      sel_d = clk_sel_i;
    end
    if (done)           irqf_d = 1'b1;
    else if (irq_ack_i) irqf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      pin_q   <= '0;
      pd_q    <= 1'b1;
      sel_q   <= 3'b000;
      irqf_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      pin_q   <= pin_d;
      pd_q    <= pd_d;
      sel_q   <= sel_d;
      irqf_q  <= irqf_d;
    end
  end

  adc_prescaler u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_q),
    .restart_i (launch),
    .tick_o    (tick)
  );

  adc_sar_fsm #(.DW(DW)) u_sar (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_i         (pd_q),
    .start_rise_i (rise),
    .start_fall_i (fall),
    .sel_ok_i     (sel_legal(sel_q)),
    .tick_i       (tick),
    .cmp_i        (cmp_i),
    .launch_o     (launch),
    .done_o       (done),
    .eoc_o        (eoc_o),
    .sample_o     (sample_o),
    .dac_code_o   (dac_code_o),
    .result_o     (result_o)
  );

  assign analog_en_o = pin_q;
  assign ctrl_o      = {start_q, eoc_o, {(6-NPIN){1'b0}}, pin_q};
  assign cfg_o       = {pd_q, 4'b0000, sel_q};
  assign irq_flag_o  = irqf_q;
  assign irq_o       = irqf_q && int_en_i;

  // R9
  assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqf_q) |-> !eoc_o)
    else $error("irq_on_done_chk");

  // R2
  assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[6:3] == 4'b0000))
    else $error("unused_zero_chk");
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we, start_i, cfg_we, pd_i, int_en_i, irq_ack_i, cmp_i;
  logic [3:0] pin_sel_i;
  logic [2:0] clk_sel_i;
  logic [7:0] dac_code_o, result_o, ctrl_o, cfg_o;
  logic       sample_o, eoc_o, irq_flag_o, irq_o;
  logic [3:0] analog_en_o;
  logic [7:0] vin;
  int         n_chk = 0, n_fail = 0;
  bit         done_flag = 0;

  always #10 clk = ~clk;

  assign cmp_i = (vin >= dac_code_o);

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .start_i(start_i),
    .pin_sel_i(pin_sel_i), .cfg_we(cfg_we), .pd_i(pd_i), .clk_sel_i(clk_sel_i),
    .int_en_i(int_en_i), .irq_ack_i(irq_ack_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .sample_o(sample_o), .result_o(result_o),
    .eoc_o(eoc_o), .analog_en_o(analog_en_o), .ctrl_o(ctrl_o), .cfg_o(cfg_o),
    .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'b000: return 2;   3'b001: return 8;   3'b010: return 32;
      3'b100: return 1;   3'b101: return 4;   3'b110: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic st, input logic [3:0] pins);
    @(negedge clk); ctrl_we = 1; start_i = st; pin_sel_i = pins;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_cfg(input logic pd, input logic [2:0] sel);
    @(negedge clk); cfg_we = 1; pd_i = pd; clk_sel_i = sel;
    @(negedge clk); cfg_we = 0;
  endtask

  // Full conversion with timing check; returns at negedge after completion.
  task automatic convert(input logic [2:0] sel, input logic [7:0] v, input logic ien, input string req);
    int d;
    logic [7:0] old;
    d = div_of(sel);
    wr_cfg(1'b0, sel);
    int_en_i = ien;
    wr_ctrl(1'b1, 4'b0011);
    check("R3", eoc_o, 1);
    vin = v;
    old = result_o;
    wr_ctrl(1'b0, 4'b0011);
    repeat (9*d-1) @(negedge clk);
    check({req, " eoc before 9N"}, eoc_o, 1);
    check("R10 result held", result_o, old);
    @(negedge clk);
    check({req, " eoc at 9N"}, eoc_o, 0);
    check("R4 result", result_o, v);
    check("R9 flag", irq_flag_o, 1);
    check("R9 irq gate", irq_o, ien);
  endtask

  initial begin
    logic [7:0] r;
    logic [2:0] legal [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
    void'($urandom(32'd1234));
    rst_n = 0; ctrl_we = 0; start_i = 0; cfg_we = 0; pd_i = 0; pin_sel_i = 0;
    clk_sel_i = 0; int_en_i = 0; irq_ack_i = 0; vin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 eoc", eoc_o, 0);
    check("R1 result", result_o, 0);
    check("R1 flag", irq_flag_o, 0);
    check("R1 cfg", cfg_o, 8'h80);
    check("R1 ctrl", ctrl_o, 8'h00);
    check("R2 digital pins", analog_en_o, 4'b0000);

    // R7: start pulse while powered down is ignored
    wr_ctrl(1'b1, 4'b0000);
    check("R7 no hold when off", eoc_o, 0);
    wr_ctrl(1'b0, 4'b0000);
    repeat (40) @(negedge clk);
    check("R7 no conversion", irq_flag_o, 0);

    // R2 readback layout
    wr_cfg(1'b0, 3'b101);
    check("R2 cfg layout", cfg_o, 8'h05);
    wr_ctrl(1'b0, 4'b1010);
    check("R2 ctrl layout", ctrl_o, 8'h0A);
    check("R2 analog enables", analog_en_o, 4'b1010);

    // R5: every legal divider
    for (int i = 0; i < 6; i++) convert(legal[i], 8'(8'h11 * (i+3)), 1'b1, "R5");

    // R9 ack
    @(negedge clk); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
    check("R9 ack clears", irq_flag_o, 0);

    // R3: holding start high keeps reset
    wr_cfg(1'b0, 3'b100);
    vin = 8'h5A;
    wr_ctrl(1'b1, 4'b0001);
    repeat (50) @(negedge clk);
    check("R3 held eoc", eoc_o, 1);
    check("R3 held no flag", irq_flag_o, 0);
    check("R3 held ctrl", ctrl_o, 8'hC1);

    // R6: illegal code stops clock, start ignored
    r = result_o;
    wr_cfg(1'b0, 3'b011);
    wr_ctrl(1'b0, 4'b0001);
    repeat (300) @(negedge clk);
    check("R6 eoc stays", eoc_o, 1);
    check("R6 result unchanged", result_o, r);
    check("R6 no flag", irq_flag_o, 0);
    wr_cfg(1'b0, 3'b111);
    wr_ctrl(1'b1, 4'b0001);
    wr_ctrl(1'b0, 4'b0001);
    repeat (300) @(negedge clk);
    check("R6 code 111 ignored", irq_flag_o, 0);

    // R8: restart mid-conversion
    wr_cfg(1'b0, 3'b001);
    wr_ctrl(1'b1, 4'b0001);
    vin = 8'h33;
    wr_ctrl(1'b0, 4'b0001);
    repeat (30) @(negedge clk);
    check("R10 mid result", result_o, r);
    wr_ctrl(1'b1, 4'b0001);
    repeat (100) @(negedge clk);
    check("R8 abandoned eoc", eoc_o, 1);
    check("R8 abandoned no flag", irq_flag_o, 0);
    vin = 8'hC7;
    wr_ctrl(1'b0, 4'b0001);
    repeat (75) @(negedge clk);
    check("R8 fresh result", result_o, 8'hC7);
    check("R8 fresh eoc", eoc_o, 0);

    // R7: power-down abandons a conversion
    @(negedge clk); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
    wr_ctrl(1'b1, 4'b0001);
    vin = 8'h0F;
    wr_ctrl(1'b0, 4'b0001);
    repeat (10) @(negedge clk);
    wr_cfg(1'b1, 3'b001);
    repeat (100) @(negedge clk);
    check("R7 abandoned result", result_o, 8'hC7);
    check("R7 abandoned flag", irq_flag_o, 0);

    // Random conversions
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
      convert(legal[$urandom % 6], 8'($urandom), 1'($urandom), "R5 rnd");
    end
    // Corner levels
    convert(3'b100, 8'h00, 1'b0, "R4 zero");
    convert(3'b100, 8'hFF, 1'b1, "R4 full");
    done_flag = 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done_flag || n_chk < 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150001) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule